// File: doc/BRIEF.md
# Slot-rotated shared interrupt router

This block gathers level-sensitive interrupt requests from up to 64 request sources and folds them onto four shared interrupt lines. Each source announces a change of one of its four request pins (INTA to INTD) as a single-cycle event. The event carries the source index, the slot number of the device and the pin. The shared line the pin lands on is chosen by rotating the pin by the slot, so devices in neighbouring slots spread their INTA pins over different lines.

For every source the block keeps one level bit per shared line. A shared line is active while any source holds its bit for that line. Four byte-wide route registers, written through a small register write port, steer each shared line onto one of 16 legacy interrupt controller inputs. A route value of 16 or more parks the line, and every route starts parked after reset. The 16-bit output vector is registered. An event or a route write sampled at a clock edge is visible on the outputs right after that same edge.

The block has no state machine. It is a level store, a route register bank and a combinational steering network, feeding one output register.

Top module: `pirq_router`

## Requirements
- R1: After reset `irq_out` is all zero, every stored level is clear and every route register holds 0x80 (parked). A source that raises a request before any route is written produces no output.
- R2: An event with source slot S (the device-number field, i.e. bits 7:3 of the bus device/function address) and pin P (0=INTA, 1=INTB, 2=INTC, 3=INTD) acts on shared line (P + S) mod 4. Only the two low bits of S matter, so slots 1, 5 and 31 shift the pin by 1, 1 and 3 respectively.
- R3: An event writes `ev_level` into the one stored bit selected by its source and its line. Bits of the same source for other lines, and bits of other sources, keep their values.
- R4: A shared line is active exactly while at least one source has its bit for that line set.
- R5: A write with `cfg_we` high and `cfg_addr` equal to 0x60, 0x61, 0x62 or 0x63 stores `cfg_wdata` in the route register of line 0, 1, 2 or 3. A write to any other address changes no route register.
- R6: A route value V in 0..15 drives `irq_out[V]` from its line. Any value of 16 or more (for example 0x10, 0x80, 0xFF) routes the line nowhere.
- R7: When several lines route to the same output bit, that bit is the OR of their line levels.
- R8: `irq_out` is registered. An event or route write sampled at a rising edge is reflected in `irq_out` immediately after that edge, and the output holds steady between edges.
- R9: Rewriting a route register of an active line moves its level from the old output bit to the new one at the same edge. The old bit drops unless another line still drives it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Request-change event strobe |
| ev_src | input | 6 | Index of the source whose pin changed |
| ev_slot | input | 5 | Slot number of that source (bits 7:3 of its device/function address) |
| ev_pin | input | 2 | Pin that changed: 0=INTA .. 3=INTD |
| ev_level | input | 1 | New level of that pin |
| cfg_we | input | 1 | Route register write strobe |
| cfg_addr | input | 8 | Register byte address; 0x60..0x63 select line 0..3 |
| cfg_wdata | input | 8 | Route value to store |
| irq_out | output | 16 | Registered interrupt controller input levels |

## Verification
The bench chooses slot values whose low bits wrap the rotation past line 3 (slot 31 with INTB). A design that used the slot unmasked or added in the wrong direction would light the wrong output bit. Several sources share one line and are cleared one at a time, and one source is driven on two lines at once. This catches a store that keeps a single bit per line, or one where clearing a bit disturbs its neighbours. Route values 0x10 and 0x8C are written to an active line: a decoder that looked only at the low four bits would wrongly drive bits 0 and 12. Two lines are merged onto one output and released in turn, rejected addresses 0x5F and 0x64 are written, and a second reset must park the routes again; a behavioural model compared on every clock catches any cycle slip in the output register.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    // Slot numbers are the device field of a bus device/function address.
    localparam int SLOT_W      = 5;
    // Route registers are byte wide; the reset value parks the line.
    localparam int ROUTE_W     = 8;
    localparam logic [ROUTE_W-1:0] ROUTE_PARKED = 8'h80;
    // Byte address of the route register of line 0; lines follow upward.
    localparam logic [7:0] ROUTE_BASE = 8'h60;
    typedef logic [ROUTE_W-1:0] route_t;
endpackage

// File: rtl/pirq_level_store.sv
module pirq_level_store
    import pirq_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int N_LINE = 4,
    localparam int SRC_W  = $clog2(N_SRC),
    localparam int LINE_W = $clog2(N_LINE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [SRC_W-1:0]  ev_src,
    input  logic [SLOT_W-1:0] ev_slot,
    input  logic [LINE_W-1:0] ev_pin,
    input  logic              ev_level,
    output logic [N_LINE-1:0] line_lvl_nxt
);
    logic [N_LINE-1:0][N_SRC-1:0] lvl_q;
    logic [N_LINE-1:0][N_SRC-1:0] lvl_d;
    logic [LINE_W-1:0]            line_sel;
    logic [SLOT_W-1:0]            rot_sum;
    logic                         src_ok;

    // Rotation of the pin by the slot, modulo the line count.
    always_comb begin
        rot_sum  = SLOT_W'(ev_pin) + ev_slot;
        line_sel = rot_sum[LINE_W-1:0];
        src_ok   = (int'(ev_src) < N_SRC);
    end

    always_comb begin
        lvl_d = lvl_q;
        if (ev_valid && src_ok) begin
            lvl_d[line_sel][ev_src] = ev_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    for (genvar l = 0; l < N_LINE; l++) begin : g_line_or
        assign line_lvl_nxt[l] = |lvl_d[l];
    end

    // R3: an event leaves its level in the selected bit
    p_event_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && src_ok) |=> (lvl_q[$past(line_sel)][$past(ev_src)] == $past(ev_level)));

    // R3: at most one stored bit changes per cycle
    p_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lvl_q ^ $past(lvl_q)) <= 1);

    // R3: without an event the store is untouched
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> $stable(lvl_q));
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_pkg::*;
#(
    parameter int N_LINE = 4,
    localparam int LINE_W = $clog2(N_LINE)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [7:0]               cfg_addr,
    input  logic [ROUTE_W-1:0]       cfg_wdata,
    output route_t [N_LINE-1:0]      route_q,
    output route_t [N_LINE-1:0]      route_nxt
);
    logic              addr_hit;
    logic [LINE_W-1:0] addr_idx;

    always_comb begin
        addr_hit = cfg_we && (cfg_addr[7:LINE_W] == ROUTE_BASE[7:LINE_W]);
        addr_idx = cfg_addr[LINE_W-1:0];
    end

    always_comb begin
        route_nxt = route_q;
        if (addr_hit) begin
            route_nxt[addr_idx] = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= {N_LINE{ROUTE_PARKED}};
        end else begin
            route_q <= route_nxt;
        end
    end

    // R5: writes outside the route window leave every route as it was
    p_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |=> $stable(route_q));

    // R5: a hit stores the written byte
    p_hit_stored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |=> (route_q[$past(addr_idx)] == $past(cfg_wdata)));
endmodule

// File: rtl/pirq_irq_mux.sv
module pirq_irq_mux
    import pirq_pkg::*;
#(
    parameter int N_LINE = 4,
    parameter int N_IRQ  = 16,
    localparam int IRQ_W = $clog2(N_IRQ)
) (
    input  logic [N_LINE-1:0]   line_lvl,
    input  route_t [N_LINE-1:0] route,
    output logic [N_IRQ-1:0]    irq_vec
);
    always_comb begin
        irq_vec = '0;
        for (int p = 0; p < N_LINE; p++) begin
            if (line_lvl[p] && (route[p] < ROUTE_W'(N_IRQ))) begin
                irq_vec[route[p][IRQ_W-1:0]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int N_SRC  = 64,
    parameter int N_LINE = 4,
    parameter int N_IRQ  = 16,
    localparam int SRC_W  = $clog2(N_SRC),
    localparam int LINE_W = $clog2(N_LINE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [SRC_W-1:0]  ev_src,
    input  logic [SLOT_W-1:0] ev_slot,
    input  logic [LINE_W-1:0] ev_pin,
    input  logic              ev_level,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [N_IRQ-1:0]  irq_out
);
    logic [N_LINE-1:0]   line_lvl_nxt;
    route_t [N_LINE-1:0] route_q;
    route_t [N_LINE-1:0] route_nxt;
    logic [N_IRQ-1:0]    irq_d;

    pirq_level_store #(.N_SRC(N_SRC), .N_LINE(N_LINE)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_valid     (ev_valid),
        .ev_src       (ev_src),
        .ev_slot      (ev_slot),
        .ev_pin       (ev_pin),
        .ev_level     (ev_level),
        .line_lvl_nxt (line_lvl_nxt)
    );

    pirq_route_regs #(.N_LINE(N_LINE)) u_routes (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .route_q   (route_q),
        .route_nxt (route_nxt)
    );

    pirq_irq_mux #(.N_LINE(N_LINE), .N_IRQ(N_IRQ)) u_mux (
        .line_lvl (line_lvl_nxt),
        .route    (route_nxt),
        .irq_vec  (irq_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out <= '0;
        end else begin
            irq_out <= irq_d;
        end
    end

    // Checker view: which output bits have any route pointing at them.
    logic [N_IRQ-1:0] routed_mask;
    logic             all_parked;
    always_comb begin
        routed_mask = '0;
        all_parked  = 1'b1;
        for (int p = 0; p < N_LINE; p++) begin
            for (int j = 0; j < N_IRQ; j++) begin
                if (route_q[p] == ROUTE_W'(j)) routed_mask[j] = 1'b1;
            end
            if (route_q[p] < ROUTE_W'(N_IRQ)) all_parked = 1'b0;
        end
    end

    // R6: parked routes drive nothing
    p_parked_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        all_parked |-> (irq_out == '0));

    // R6: an output bit is only set when some route names it
    p_only_routed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~routed_mask) == '0));

    // R7: no more output bits are set than there are lines
    p_bits_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= N_LINE);
endmodule

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [5:0]  ev_src = '0;
    logic [4:0]  ev_slot = '0;
    logic [1:0]  ev_pin = '0;
    logic        ev_level = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pirq_router dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_src(ev_src),
        .ev_slot(ev_slot), .ev_pin(ev_pin), .ev_level(ev_level),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .irq_out(irq_out)
    );

    // Behavioural reference model
    bit          m_lvl [4][64];
    int          m_route [4];
    logic [15:0] m_exp = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_lvl[p, s]) m_lvl[p][s] = 1'b0;
            foreach (m_route[p]) m_route[p] = 128;
        end else begin
            if (ev_valid) m_lvl[(int'(ev_pin) + int'(ev_slot)) % 4][ev_src] = ev_level;
            if (cfg_we && cfg_addr >= 8'h60 && cfg_addr <= 8'h63)
                m_route[cfg_addr - 8'h60] = int'(cfg_wdata);
        end
        m_exp = '0;
        for (int p = 0; p < 4; p++) begin
            bit any;
            any = 1'b0;
            for (int s = 0; s < 64; s++) if (m_lvl[p][s]) any = 1'b1;
            if (any && m_route[p] < 16) m_exp[m_route[p]] = 1'b1;
        end
    end

    // Cycle-by-cycle comparison against the model (R8)
    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (irq_out !== m_exp) begin
                n_fails++;
                $display("FAIL R8 per-cycle: irq_out=%h expected=%h at %0t", irq_out, m_exp, $time);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] exp);
        n_checks++;
        if (irq_out !== exp) begin
            n_fails++;
            $display("FAIL %s: irq_out=%h expected=%h", req, irq_out, exp);
        end
    endtask

    task automatic ev(input int src, input int slot, input int pin, input bit lvl);
        ev_src = 6'(src); ev_slot = 5'(slot); ev_pin = 2'(pin); ev_level = lvl;
        ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset output", 16'h0000);
        ev(0, 0, 0, 1);
        chk("R1 parked after reset", 16'h0000);
        wr(8'h60, 8'd11);
        chk("R8 route write visible next edge", 16'h0800);
        wr(8'h61, 8'd9); wr(8'h62, 8'd5); wr(8'h63, 8'd3);
        chk("R5 other lines idle", 16'h0800);
        ev(2, 1, 0, 1);
        chk("R2 slot1 INTA to line1", 16'h0A00);
        ev(3, 5, 2, 1);
        chk("R2 slot5 INTC to line3", 16'h0A08);
        ev(4, 31, 1, 1);
        ev(0, 0, 0, 0);
        chk("R4 line0 held by second source", 16'h0A08);
        ev(4, 31, 1, 0);
        chk("R4 line0 released", 16'h0208);
        ev(2, 1, 1, 1);
        chk("R3 same source two lines", 16'h0228);
        ev(2, 1, 0, 0);
        chk("R3 clear one line only", 16'h0028);
        wr(8'h63, 8'd5);
        chk("R7 two lines merged", 16'h0020);
        ev(2, 1, 1, 0);
        chk("R7 merged bit held by other line", 16'h0020);
        ev(3, 5, 2, 0);
        chk("R7 merged bit released", 16'h0000);
        ev(5, 2, 2, 1);
        chk("R2 slot2 INTC to line0", 16'h0800);
        wr(8'h60, 8'd12);
        chk("R9 reroute moves level", 16'h1000);
        wr(8'h64, 8'h00); wr(8'h5F, 8'h00);
        chk("R5 stray addresses ignored", 16'h1000);
        wr(8'h60, 8'h10);
        chk("R6 value 0x10 parks", 16'h0000);
        wr(8'h60, 8'h8C);
        chk("R6 value 0x8C parks", 16'h0000);
        wr(8'h60, 8'd15);
        chk("R6 value 15", 16'h8000);
        wr(8'h60, 8'd0);
        chk("R6 value 0", 16'h0001);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears output", 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        ev(5, 2, 2, 1);
        chk("R1 routes parked again", 16'h0000);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule